// File: doc/BRIEF.md
# Overcurrent Event Accumulator Detector

This block decides whether a switching converter is in an overcurrent condition by watching a digitized current-sense comparator across many switching cycles, rather than tripping on a single comparator pulse. At the rising edge of the gate-drive signal it starts a blanking interval that hides switching noise. It then records whether the comparator asserted during the remaining on-time. When the gate turns off, it moves a small saturating counter up by one after a cycle that had an event and down by one after a clean cycle.

A fault is declared when the counter reaches a programmable threshold. While the fault is active, a gate-inhibit output is raised and the counter is frozen. A mode input chooses how the fault ends. A soft fault can be cleared by a restart pulse. A hard fault stays until the block is reset, and the reset stands in for a supply power cycle.

Top module: `ocp_accum_detector`

## Requirements
- R1: After reset, `fault_o` and `inhibit_o` are 0 and the internal event count is 0.
- R2: With `blank_code_i` = N, a comparator assertion during the first N clock cycles of the on-time is ignored. The rising-edge cycle is the first of these N cycles. An assertion in cycle N after the rising edge is counted. With N = 0, the rising-edge cycle itself is counted.
- R3: A comparator assertion while `gate_i` is low is never counted as an event.
- R4: On the clock cycle in which `gate_i` is first seen low after being high, the count moves up by 1 if the on-time just ended held an event and down by 1 otherwise. The count saturates at 0 and at 2^CNT_W-1.
- R5: A fault is declared when the updated count is greater than or equal to the threshold code `thresh_code_i`. A threshold code of 0 acts as 1. `fault_o` rises one clock after the first low-gate cycle.
- R6: `inhibit_o` is high exactly while `fault_o` is high, and the count is frozen during a fault.
- R7: When `latch_mode_i` = 0 at the moment the fault is declared, a `restart_i` pulse clears `fault_o` and resets the count to 0.
- R8: When `latch_mode_i` = 1 at the moment the fault is declared, `restart_i` has no effect and only reset clears the fault.
- R9: When `en_n_i` = 1, the detector is off: no events are taken, the count is held at 0, and no fault can be declared.
- R10: Any number of qualified assertions within one on-time add exactly 1 to the count. The per-cycle event flag is cleared at the next rising edge of the gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power cycle) |
| gate_i | input | 1 | Gate-drive level, 1 = switch on |
| cmp_i | input | 1 | Digitized overcurrent comparator output |
| en_n_i | input | 1 | Active-low detector enable |
| latch_mode_i | input | 1 | 1 = hard (latched) fault, 0 = soft fault |
| blank_code_i | input | BLANK_W | Blanking length in clock cycles |
| thresh_code_i | input | CNT_W | Fault threshold for the event count |
| restart_i | input | 1 | Restart pulse that clears a soft fault |
| fault_o | output | 1 | Fault declared |
| inhibit_o | output | 1 | Gate inhibit, high while faulted |

## Verification
The main function is driven with sequences of switching cycles that each carry a different comparator pattern. One pattern is a pulse wholly inside the blanking window, which shows whether blanking masks events. One pulse starts exactly on the first unblanked cycle and another falls on the last on-cycle, which locate the blanking boundary and the end of the qualified window. One pattern holds the comparator high only while the gate is low, which shows whether an off-time assertion is taken as an event. A burst of several high cycles within one on-time shows whether the event flag counts once per switching cycle and not once per assertion. Runs of clean cycles followed by event cycles show the floor of the counter and show that the fault trips at the threshold and not one cycle early or late.

// File: rtl/ocp_accum_pkg.sv
package ocp_accum_pkg;

  // widest counter the helper functions handle
  localparam int unsigned ACC_MAX_W = 8;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_SOFT = 2'd1,
    FLT_HARD = 2'd2
  } flt_state_e;

  // saturating one-step move of the event count
  function automatic logic [ACC_MAX_W-1:0] acc_step_f(
    input logic [ACC_MAX_W-1:0] acc,
    input logic                 up,
    input int unsigned          w
  );
    logic [ACC_MAX_W-1:0] top;
    top = ACC_MAX_W'((9'd1 << w) - 9'd1);
    if (up) return (acc >= top) ? top : acc + 1'b1;
    else    return (acc == '0) ? '0 : acc - 1'b1;
  endfunction

  // threshold code 0 is treated as 1
  function automatic logic [ACC_MAX_W-1:0] thr_eff_f(input logic [ACC_MAX_W-1:0] code);
    return (code == '0) ? ACC_MAX_W'(1) : code;
  endfunction

  function automatic logic fault_hit_f(
    input logic [ACC_MAX_W-1:0] acc,
    input logic [ACC_MAX_W-1:0] code
  );
    return acc >= thr_eff_f(code);
  endfunction

  // value loaded into the blanking down-counter at the gate rising edge
  function automatic logic [ACC_MAX_W-1:0] blank_load_f(input logic [ACC_MAX_W-1:0] code);
    return (code == '0) ? '0 : code - 1'b1;
  endfunction

endpackage

// File: rtl/ocp_edge_blank.sv
module ocp_edge_blank #(
  parameter int unsigned BLANK_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               gate_i,
  input  logic [BLANK_W-1:0] blank_code_i,
  output logic               gate_rise_o,
  output logic               gate_fall_o,
  output logic               blank_active_o
);
  import ocp_accum_pkg::*;

  logic gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_i;
  end

  assign gate_rise_o = gate_i & ~gate_q;
  assign gate_fall_o = ~gate_i & gate_q;

  generate
    if (BLANK_W == 0) begin : g_no_blank
      assign blank_active_o = 1'b0;
    end else begin : g_blank
      logic [BLANK_W-1:0] cnt_q;
      logic               code_nz;

      assign code_nz = |blank_code_i;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
        end else if (gate_rise_o) begin
          cnt_q <= BLANK_W'(blank_load_f(ACC_MAX_W'(blank_code_i)));
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end

      // the rising-edge cycle is blanked when the code is non-zero
      assign blank_active_o = gate_i & (gate_rise_o ? code_nz : (cnt_q != '0));
    end
  endgenerate

endmodule

// File: rtl/ocp_event_capture.sv
module ocp_event_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  input  logic cmp_i,
  input  logic blank_active_i,
  input  logic gate_rise_i,
  input  logic arm_i,
  input  logic clear_i,
  output logic evt_qual_o,
  output logic evt_flag_o
);

  logic flag_q;

  assign evt_qual_o = arm_i & gate_i & ~blank_active_i & cmp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (clear_i) begin
      flag_q <= 1'b0;
    end else if (gate_rise_i) begin
      flag_q <= evt_qual_o;
    end else if (evt_qual_o) begin
      flag_q <= 1'b1;
    end
  end

  assign evt_flag_o = flag_q;

endmodule

// File: rtl/ocp_accum.sv
module ocp_accum #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             up_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] acc_o,
  output logic [CNT_W-1:0] acc_next_o
);
  import ocp_accum_pkg::*;

  logic [CNT_W-1:0] acc_q;

  assign acc_next_o = CNT_W'(acc_step_f(ACC_MAX_W'(acc_q), up_i, CNT_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (step_i)  acc_q <= acc_next_o;
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/ocp_fault_ctl.sv
module ocp_fault_ctl #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [CNT_W-1:0] acc_next_i,
  input  logic [CNT_W-1:0] thresh_code_i,
  input  logic             latch_mode_i,
  input  logic             restart_i,
  output logic             fault_o,
  output logic             latched_o,
  output logic             restart_ok_o,
  output logic             fault_set_o
);
  import ocp_accum_pkg::*;

  flt_state_e state_q, state_d;

  assign fault_o      = (state_q != FLT_NONE);
  assign latched_o    = (state_q == FLT_HARD);
  assign restart_ok_o = restart_i & ~latched_o;
  assign fault_set_o  = step_i & ~fault_o &
                        fault_hit_f(ACC_MAX_W'(acc_next_i), ACC_MAX_W'(thresh_code_i));

  always_comb begin
    state_d = state_q;
    if (restart_ok_o)     state_d = FLT_NONE;
    else if (fault_set_o) state_d = latch_mode_i ? FLT_HARD : FLT_SOFT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= FLT_NONE;
    else         state_q <= state_d;
  end

endmodule

// File: rtl/ocp_accum_detector.sv
module ocp_accum_detector #(
  parameter int unsigned BLANK_W = 4,
  parameter int unsigned CNT_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               gate_i,
  input  logic               cmp_i,
  input  logic               en_n_i,
  input  logic               latch_mode_i,
  input  logic [BLANK_W-1:0] blank_code_i,
  input  logic [CNT_W-1:0]   thresh_code_i,
  input  logic               restart_i,
  output logic               fault_o,
  output logic               inhibit_o
);

  // named internal events, observed by the bound checker
  logic             gate_rise;
  logic             gate_fall;
  logic             blank_active;
  logic             evt_qual;
  logic             evt_flag;
  logic             acc_step;
  logic [CNT_W-1:0] acc_q;
  logic [CNT_W-1:0] acc_next;
  logic             fault_set;
  logic             restart_ok;
  logic             latched;
  logic             en_ok;
  logic             fault_q;
  logic             clr_all;

  assign en_ok   = ~en_n_i;
  assign clr_all = restart_ok | ~en_ok;

  ocp_edge_blank #(.BLANK_W(BLANK_W)) u_edge (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .gate_i         (gate_i),
    .blank_code_i   (blank_code_i),
    .gate_rise_o    (gate_rise),
    .gate_fall_o    (gate_fall),
    .blank_active_o (blank_active)
  );

  ocp_event_capture u_cap (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .gate_i         (gate_i),
    .cmp_i          (cmp_i),
    .blank_active_i (blank_active),
    .gate_rise_i    (gate_rise),
    .arm_i          (en_ok & ~fault_q),
    .clear_i        (clr_all),
    .evt_qual_o     (evt_qual),
    .evt_flag_o     (evt_flag)
  );

  assign acc_step = gate_fall & en_ok & ~fault_q;

  ocp_accum #(.CNT_W(CNT_W)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (acc_step),
    .up_i       (evt_flag),
    .clear_i    (clr_all),
    .acc_o      (acc_q),
    .acc_next_o (acc_next)
  );

  ocp_fault_ctl #(.CNT_W(CNT_W)) u_flt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .step_i        (acc_step),
    .acc_next_i    (acc_next),
    .thresh_code_i (thresh_code_i),
    .latch_mode_i  (latch_mode_i),
    .restart_i     (restart_i),
    .fault_o       (fault_q),
    .latched_o     (latched),
    .restart_ok_o  (restart_ok),
    .fault_set_o   (fault_set)
  );

  assign fault_o   = fault_q;
  assign inhibit_o = fault_q;

endmodule

// File: rtl/ocp_accum_detector_chk.sv
module ocp_accum_detector_chk #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             gate_i,
  input logic             en_n_i,
  input logic             blank_active,
  input logic             evt_qual,
  input logic             gate_fall,
  input logic             acc_step,
  input logic [CNT_W-1:0] acc_q,
  input logic             fault_o,
  input logic             inhibit_o,
  input logic             fault_set,
  input logic             restart_ok,
  input logic             latched
);

  p_blank_masks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_active |-> !evt_qual);

  p_gate_low_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i |-> !evt_qual);

  p_hold_without_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_step && !restart_ok && !en_n_i) |=> $stable(acc_q));

  p_fault_after_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(gate_fall) && $past(fault_set));

  p_inhibit_tracks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_o == fault_o);

  p_frozen_in_fault_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !restart_ok && !en_n_i) |=> $stable(acc_q));

  p_restart_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_ok |=> (acc_q == '0) && !fault_o);

  p_hard_fault_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && latched) |=> fault_o);

  p_disabled_no_fault_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_n_i |=> !$rose(fault_o));

endmodule

bind ocp_accum_detector ocp_accum_detector_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .gate_i       (gate_i),
  .en_n_i       (en_n_i),
  .blank_active (blank_active),
  .evt_qual     (evt_qual),
  .gate_fall    (gate_fall),
  .acc_step     (acc_step),
  .acc_q        (acc_q),
  .fault_o      (fault_o),
  .inhibit_o    (inhibit_o),
  .fault_set    (fault_set),
  .restart_ok   (restart_ok),
  .latched      (latched)
);

// File: tb/ocp_accum_detector_tb.sv
`timescale 1ns/1ps
module ocp_accum_detector_tb;

  localparam int ON_LEN  = 8;
  localparam int OFF_LEN = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gate = 1'b0;
  logic       cmp = 1'b0;
  logic       en_n = 1'b0;
  logic       latch = 1'b0;
  logic [3:0] blank = 4'd3;
  logic [2:0] thr = 3'd4;
  logic       restart = 1'b0;
  logic       fault, inhibit;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  ocp_accum_detector u_dut (
    .clk_i(clk), .rst_ni(rst_n), .gate_i(gate), .cmp_i(cmp), .en_n_i(en_n),
    .latch_mode_i(latch), .blank_code_i(blank), .thresh_code_i(thr),
    .restart_i(restart), .fault_o(fault), .inhibit_o(inhibit)
  );

  typedef struct packed {
    logic [3:0] blk;
    logic [3:0] c_off;
    logic [3:0] c_len;
    logic       off_hi;
    logic       exp_f;
  } row_t;

  // threshold 4, on-time 8 cycles; comments give the expected count after each row
  localparam row_t ROWS [9] = '{
    '{4'd3, 4'd0, 4'd3, 1'b0, 1'b0},  // R2 all inside blanking -> 0
    '{4'd3, 4'd3, 4'd1, 1'b0, 1'b0},  // R2 first unblanked cycle -> 1
    '{4'd3, 4'd7, 4'd1, 1'b0, 1'b0},  // R10 last on-cycle -> 2
    '{4'd3, 4'd0, 4'd0, 1'b1, 1'b0},  // R3 high only while off -> 1
    '{4'd3, 4'd2, 4'd1, 1'b0, 1'b0},  // R2 blanked -> 0
    '{4'd3, 4'd4, 4'd3, 1'b0, 1'b0},  // R10 burst counts once -> 1
    '{4'd3, 4'd4, 4'd1, 1'b0, 1'b0},  // R4 -> 2
    '{4'd0, 4'd0, 4'd1, 1'b0, 1'b0},  // R2 zero blanking, rise cycle -> 3
    '{4'd3, 4'd4, 4'd1, 1'b0, 1'b1}   // R5 reaches 4 -> fault
  };

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic on_phase(input int c_off, input int c_len);
    for (int k = 0; k < ON_LEN; k++) begin
      @(negedge clk);
      gate = 1'b1;
      cmp  = (k >= c_off) && (k < c_off + c_len);
    end
  endtask

  task automatic sw_cycle(input int c_off, input int c_len, input bit off_hi);
    on_phase(c_off, c_len);
    for (int k = 0; k < OFF_LEN; k++) begin
      @(negedge clk);
      gate = 1'b0;
      cmp  = off_hi;
    end
    @(negedge clk);
    cmp = 1'b0;
  endtask

  task automatic pulse_restart();
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 fault after reset", fault, 1'b0);
    chk("R1 inhibit after reset", inhibit, 1'b0);

    // table walk
    for (int i = 0; i < 9; i++) begin
      blank = ROWS[i].blk;
      sw_cycle(int'(ROWS[i].c_off), int'(ROWS[i].c_len), ROWS[i].off_hi);
      chk($sformatf("R2/R3/R4/R5/R10 row %0d fault", i), fault, ROWS[i].exp_f);
    end
    blank = 4'd3;

    // R6: inhibit follows fault, events ignored while faulted
    chk("R6 inhibit high in fault", inhibit, 1'b1);
    sw_cycle(4, 1, 1'b0);
    chk("R6 fault held", fault, 1'b1);

    // R7: soft restart clears fault and count (count 4 frozen -> cleared)
    pulse_restart();
    chk("R7 fault cleared by restart", fault, 1'b0);
    chk("R6 inhibit low after restart", inhibit, 1'b0);
    sw_cycle(4, 1, 1'b0);
    chk("R7 count restarted from 0", fault, 1'b0);   // count 1

    // R5: threshold code 0 acts as 1, and fault timing
    thr = 3'd0;
    sw_cycle(0, 0, 1'b0);                               // count 0
    chk("R5 threshold 0 no fault at count 0", fault, 1'b0);
    on_phase(4, 1);
    @(negedge clk); gate = 1'b0; cmp = 1'b0;
    #1 chk("R5 fault not yet in first off cycle", fault, 1'b0);
    @(negedge clk);
    chk("R5 fault one clock after first off cycle", fault, 1'b1);
    repeat (2) @(negedge clk);
    pulse_restart();

    // R4: floor saturation at 0
    thr = 3'd2;
    sw_cycle(0, 0, 1'b0);
    sw_cycle(0, 0, 1'b0);
    sw_cycle(0, 0, 1'b0);
    sw_cycle(4, 1, 1'b0);
    chk("R4 count 1 after floor", fault, 1'b0);
    sw_cycle(4, 1, 1'b0);
    chk("R4 count 2 reaches threshold", fault, 1'b1);
    pulse_restart();

    // R9: disabled detector
    en_n = 1'b1;
    thr  = 3'd1;
    sw_cycle(4, 2, 1'b0);
    sw_cycle(4, 2, 1'b0);
    chk("R9 no fault while disabled", fault, 1'b0);
    en_n = 1'b0;
    thr  = 3'd2;
    sw_cycle(4, 1, 1'b0);
    chk("R9 count held at 0 while disabled", fault, 1'b0);
    pulse_restart();

    // R8: hard fault ignores restart, cleared only by reset
    latch = 1'b1;
    thr   = 3'd1;
    sw_cycle(4, 1, 1'b0);
    chk("R8 hard fault declared", fault, 1'b1);
    latch = 1'b0;
    pulse_restart();
    chk("R8 restart ignored on hard fault", fault, 1'b1);
    chk("R8 inhibit still high", inhibit, 1'b1);
    do_reset();
    chk("R8/R1 reset clears hard fault", fault, 1'b0);
    chk("R1 inhibit low after reset", inhibit, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule